// File: doc/BRIEF.md
# Pipelined Barrett Modular Multiplier

This block computes `(a * b) mod q` for residues `a` and `b` below an odd modulus `q` that lies strictly between 2^30 and 2^31. The caller also supplies the reduction constant `mu = floor(2^62 / q)`, which fits in 32 bits for any modulus in that range. Each operation carries its own `q` and `mu`, so consecutive operations may use different moduli.

The operation uses three wide multiplies. The first forms the 62-bit product `x = a*b`. The second forms the quotient estimate `qhat = ((x >> 30) * mu) >> 32`. The third forms `qhat * q`. Each of these is a 32x32 product. It is built from four 16x16 partial products that share one small multiplier, one partial product per cycle. Each multiply stage takes six cycles. The remainder `x - qhat*q` is formed in 33 bits, and at most two conditional subtractions of `q` bring it into range.

The three stages are chained so that their work overlaps. The block takes a new operation every fourth cycle, and each result appears 19 cycles after its operation was accepted.

Top module: `modmul_barrett_pipe`

## Requirements
- R1: For `a < q` and `b < q`, with `2^30 < q < 2^31`, `q` odd and `mu_i = floor(2^62 / q)`, the result on `result_o` equals `(a*b) mod q`.
- R2: Every result is below the modulus of its own operation, and bit 31 of `result_o` is 0 whenever `out_valid_o` is high.
- R3: If an operation is accepted in cycle c (the cycle in which `in_valid_i` and `in_ready_o` are both high), `out_valid_o` is high in cycle c+19 and in no other cycle on its account. Each pulse lasts one cycle.
- R4: After an accepted operation, `in_ready_o` is low for the next three cycles and high again in the fourth.
- R5: If operations are offered continuously, one is accepted every four cycles. Their results come out every four cycles, in the order the operations were accepted.
- R6: While `in_ready_o` is low, the values on `in_valid_i`, `a_i`, `b_i`, `q_i` and `mu_i` are ignored. They produce no result and do not alter results already in flight.
- R7: While reset is asserted and right after it is released, `in_ready_o` is 1 and `out_valid_o` is 0.
- R8: While no operation is accepted, `out_valid_o` stays low once the operations in flight have drained.
- R9: A zero operand gives 0, and `(q-1)*(q-1)` gives 1.
- R10: Operations accepted at irregular spacings of four or more cycles, each with a different modulus, each produce the correct result 19 cycles after their own acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An operation is offered |
| in_ready_o | output | 1 | The block can accept an operation this cycle |
| a_i | input | 32 | First operand, below `q` |
| b_i | input | 32 | Second operand, below `q` |
| q_i | input | 31 | Odd modulus, between 2^30 and 2^31 |
| mu_i | input | 32 | Reduction constant `floor(2^62/q)` |
| out_valid_o | output | 1 | `result_o` holds a finished result this cycle |
| result_o | output | 32 | Modular product |

## Verification
Every result is due exactly 19 cycles after the cycle in which its operation was accepted. Readiness returns in the fourth cycle after an acceptance. The bench reads a free-running cycle count at the falling edge in which it presents each operation, and it stamps every `out_valid_o` pulse with that same count. Each check then compares the stamp with the acceptance cycle plus 19, and the value with a 64-bit reference computed in the bench. The ready-low window is sampled at the three falling edges that follow an acceptance, and again at the fourth.

// File: rtl/modmul_pkg.sv
package modmul_pkg;
  localparam int unsigned MM_W         = 32;              // operand width
  localparam int unsigned MM_NPP       = 4;               // partial products per wide multiply
  localparam int unsigned MM_STAGE_LAT = MM_NPP + 2;      // cycles from start to product
  localparam int unsigned MM_II        = MM_NPP;          // initiation interval
  localparam int unsigned MM_LAT       = 3 * MM_STAGE_LAT + 1;
endpackage

// File: rtl/mm_delay.sv
module mm_delay #(
  parameter int unsigned W = 32,
  parameter int unsigned D = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (D == 0) begin : g_wire
      assign q_o = d_i;
    end else begin : g_line
      logic [W-1:0] line_q [D];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < D; i++) line_q[i] <= '0;
        end else begin
          line_q[0] <= d_i;
          for (int i = 1; i < D; i++) line_q[i] <= line_q[i-1];
        end
      end
      assign q_o = line_q[D-1];
    end
  endgenerate
endmodule

// File: rtl/mm_seq_mul.sv
// W x W product from four (W/2) x (W/2) partial products through one multiplier.
// start_i in cycle 0 -> done_o and prod_o valid in cycle 6. Restart allowed every 4 cycles.
module mm_seq_mul #(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           done_o,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned H   = W / 2;
  localparam int unsigned NPH = modmul_pkg::MM_STAGE_LAT;

  logic [W-1:0]   a_q, b_q;
  logic [NPH-1:0] ph_q;
  logic [H-1:0]   a_half, b_half;
  logic [2*H-1:0] pp_d, pp_q;
  logic [1:0]     pp_pos_q;
  logic           pp_vld_q, pp_first_q;
  logic [2*W-1:0] pp_ext, acc_q;

  // slot order: lo*lo, lo*hi, hi*lo, hi*hi
  always_comb begin
    a_half = (ph_q[2] | ph_q[3]) ? a_q[W-1:H] : a_q[H-1:0];
    b_half = (ph_q[1] | ph_q[3]) ? b_q[W-1:H] : b_q[H-1:0];
    pp_d   = a_half * b_half;
  end

  always_comb begin
    case (pp_pos_q)
      2'd1:    pp_ext = {{(2*W-2*H){1'b0}}, pp_q} << H;
      2'd2:    pp_ext = {{(2*W-2*H){1'b0}}, pp_q} << (2*H);
      default: pp_ext = {{(2*W-2*H){1'b0}}, pp_q};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q        <= '0;
      b_q        <= '0;
      ph_q       <= '0;
      pp_q       <= '0;
      pp_pos_q   <= '0;
      pp_vld_q   <= 1'b0;
      pp_first_q <= 1'b0;
      acc_q      <= '0;
    end else begin
      ph_q <= {ph_q[NPH-2:0], start_i};
      if (start_i) begin
        a_q <= a_i;
        b_q <= b_i;
      end
      pp_q       <= pp_d;
      pp_vld_q   <= |ph_q[3:0];
      pp_first_q <= ph_q[0];
      pp_pos_q   <= {ph_q[3], ph_q[1] | ph_q[2]};
      if (pp_vld_q) acc_q <= pp_first_q ? pp_ext : acc_q + pp_ext;
    end
  end

  assign done_o = ph_q[NPH-1];
  assign prod_o = acc_q;
endmodule

// File: rtl/mm_barrett_fix.sv
// Remainder in W+1 bits, two conditional subtractions, output register.
module mm_barrett_fix #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W:0]   x_i,
  input  logic [W:0]   p_i,
  input  logic [W-2:0] q_i,
  output logic         valid_o,
  output logic [W-1:0] res_o
);
  logic [W:0] q_ext, r0, r1, r2;
  logic       unused_top;

  always_comb begin
    q_ext = {2'b00, q_i};
    r0    = x_i - p_i;
    r1    = (r0 >= q_ext) ? r0 - q_ext : r0;
    r2    = (r1 >= q_ext) ? r1 - q_ext : r1;
  end
  assign unused_top = r2[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= r2[W-1:0];
    end
  end
endmodule

// File: rtl/modmul_barrett_pipe.sv
module modmul_barrett_pipe #(
  parameter int unsigned W = modmul_pkg::MM_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-2:0] q_i,
  input  logic [W-1:0] mu_i,
  output logic         out_valid_o,
  output logic [W-1:0] result_o
);
  localparam int unsigned K   = W - 1;
  localparam int unsigned II  = modmul_pkg::MM_II;
  localparam int unsigned SL  = modmul_pkg::MM_STAGE_LAT;
  localparam int unsigned CW  = $clog2(II);

  logic          accept;
  logic [CW-1:0] cool_q;

  logic           done1, done2, done3;
  logic [2*W-1:0] prod1, prod2, prod3;
  logic [W-1:0]   mu_d, y, qhat;
  logic [K-1:0]   q_d_mid, q_d_end;
  logic [W:0]     x_d;
  logic           unused_bits;

  // R4: hold off the source for II-1 cycles after each acceptance
  assign accept     = in_valid_i & in_ready_o;
  assign in_ready_o = (cool_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cool_q <= '0;
    else if (accept)         cool_q <= CW'(II - 1);
    else if (cool_q != '0)   cool_q <= cool_q - 1'b1;
  end

  // stage 1: x = a*b
  mm_seq_mul #(.W(W)) i_mul_prod (
    .clk_i, .rst_ni, .start_i(accept), .a_i(a_i), .b_i(b_i),
    .done_o(done1), .prod_o(prod1)
  );

  mm_delay #(.W(W), .D(SL)) i_dly_mu (
    .clk_i, .rst_ni, .d_i(mu_i), .q_o(mu_d)
  );

  // stage 2: qhat = ((x >> (K-1)) * mu) >> (K+1)
  assign y = prod1[2*W-3:K-1];

  mm_seq_mul #(.W(W)) i_mul_est (
    .clk_i, .rst_ni, .start_i(done1), .a_i(y), .b_i(mu_d),
    .done_o(done2), .prod_o(prod2)
  );

  assign qhat = prod2[2*W-1:K+1];

  mm_delay #(.W(K), .D(2*SL)) i_dly_q_mid (
    .clk_i, .rst_ni, .d_i(q_i), .q_o(q_d_mid)
  );

  // stage 3: qhat * q
  mm_seq_mul #(.W(W)) i_mul_sub (
    .clk_i, .rst_ni, .start_i(done2), .a_i(qhat), .b_i({1'b0, q_d_mid}),
    .done_o(done3), .prod_o(prod3)
  );

  mm_delay #(.W(K), .D(SL)) i_dly_q_end (
    .clk_i, .rst_ni, .d_i(q_d_mid), .q_o(q_d_end)
  );

  mm_delay #(.W(W+1), .D(2*SL)) i_dly_x (
    .clk_i, .rst_ni, .d_i(prod1[W:0]), .q_o(x_d)
  );

  mm_barrett_fix #(.W(W)) i_fix (
    .clk_i, .rst_ni, .valid_i(done3), .x_i(x_d), .p_i(prod3[W:0]),
    .q_i(q_d_end), .valid_o(out_valid_o), .res_o(result_o)
  );

  assign unused_bits = ^{prod1[2*W-1:2*W-2], prod2[K:0], prod3[2*W-1:W+1]};
endmodule

// File: rtl/modmul_barrett_pipe_chk.sv
module modmul_barrett_pipe_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         out_valid_o,
  input logic [W-1:0] result_o
);
  localparam int unsigned LAT = modmul_pkg::MM_LAT;

  logic           acc;
  logic [LAT-1:0] acc_sh_q;

  assign acc = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_sh_q <= '0;
    else         acc_sh_q <= {acc_sh_q[LAT-2:0], acc};
  end

  p_ready_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !in_ready_o ##1 !in_ready_o ##1 !in_ready_o ##1 in_ready_o);

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == acc_sh_q[LAT-1]);

  p_single_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  p_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !result_o[W-1]);

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_sh_q == '0) |-> !out_valid_o);
endmodule

bind modmul_barrett_pipe modmul_barrett_pipe_chk #(.W(W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .result_o(result_o)
);

// File: tb/test_modmul_barrett_pipe.sv
`timescale 1ns/1ps
module test_modmul_barrett_pipe;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] a_i = '0, b_i = '0, mu_i = '0;
  logic [30:0] q_i = '0;
  logic        out_valid_o;
  logic [31:0] result_o;

  modmul_barrett_pipe i_modmul_barrett_pipe (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .a_i, .b_i, .q_i, .mu_i,
    .out_valid_o, .result_o
  );

  always #5 clk_i = ~clk_i;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int n_out = 0;
  logic [31:0] mon_val [256];
  int          mon_cyc [256];

  logic [31:0] op_a [8];
  logic [31:0] op_b [8];
  logic [30:0] op_q [8];
  int          op_gap [8];
  int          n_ops;

  logic [30:0] primes [5] = '{31'd2147483647, 31'd2147483629, 31'd2147483587,
                              31'd1610612741, 31'd1073741827};

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o && n_out < 256) begin
      mon_val[n_out] = result_o;
      mon_cyc[n_out] = cyc;
      n_out++;
    end
  end

  function automatic logic [31:0] calc_mu(input logic [30:0] q);
    logic [63:0] t;
    t = 64'h4000_0000_0000_0000 / {33'd0, q};
    return t[31:0];
  endfunction

  function automatic logic [31:0] ref_mod(input logic [31:0] a, b, input logic [30:0] q);
    logic [63:0] p;
    p = {32'd0, a} * {32'd0, b};
    p = p % {33'd0, q};
    return p[31:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // caller sits at a falling edge; returns at the falling edge after acceptance
  task automatic send_op(input logic [31:0] a, b, input logic [30:0] q, output int c);
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = 1'b1; a_i = a; b_i = b; q_i = q; mu_i = calc_mu(q);
    c = cyc;
    @(negedge clk_i);
    in_valid_i = 1'b0; a_i = '0; b_i = '0; q_i = '0; mu_i = '0;
  endtask

  task automatic run_batch(input string req);
    int base, acc_c[8];
    base = n_out;
    for (int i = 0; i < n_ops; i++) begin
      send_op(op_a[i], op_b[i], op_q[i], acc_c[i]);
      repeat (op_gap[i]) @(negedge clk_i);
    end
    repeat (24) @(negedge clk_i);
    chk(n_out - base == n_ops, req, "result count", n_out - base, n_ops);
    for (int i = 0; i < n_ops && base + i < n_out; i++) begin
      chk(mon_cyc[base+i] == acc_c[i] + 19, {req, " R3"}, "result cycle",
          mon_cyc[base+i], acc_c[i] + 19);
      chk(mon_val[base+i] == ref_mod(op_a[i], op_b[i], op_q[i]), {req, " R1"}, "result value",
          mon_val[base+i], ref_mod(op_a[i], op_b[i], op_q[i]));
      chk(mon_val[base+i] < {1'b0, op_q[i]}, "R2", "below modulus",
          mon_val[base+i], op_q[i]);
    end
  endtask

  task automatic t_reset();
    chk(in_ready_o == 1'b1, "R7", "ready in reset", in_ready_o, 1);
    chk(out_valid_o == 1'b0, "R7", "valid in reset", out_valid_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R7", "ready after reset", in_ready_o, 1);
    chk(out_valid_o == 1'b0, "R7", "valid after reset", out_valid_o, 0);
  endtask

  task automatic t_corners();
    logic [30:0] q;
    q = primes[0];
    op_a[0] = 32'd0;          op_b[0] = 32'd123456789;
    op_a[1] = 32'd987654321;  op_b[1] = 32'd0;
    op_a[2] = {1'b0, q} - 1;  op_b[2] = {1'b0, q} - 1;
    op_a[3] = 32'd1;          op_b[3] = {1'b0, q} - 1;
    op_a[4] = {1'b0, primes[4]} - 1; op_b[4] = {1'b0, primes[4]} - 1;
    for (int i = 0; i < 5; i++) begin
      op_q[i] = (i == 4) ? primes[4] : q;
      op_gap[i] = 2;
    end
    n_ops = 5;
    run_batch("R9");
    chk(mon_val[n_out-3] == 32'd1, "R9", "(q-1)^2", mon_val[n_out-3], 1);
    chk(mon_val[n_out-1] == 32'd1, "R9", "(q-1)^2 small q", mon_val[n_out-1], 1);
    chk(mon_val[n_out-5] == 32'd0, "R9", "zero operand", mon_val[n_out-5], 0);
  endtask

  task automatic t_stream();
    int base;
    for (int i = 0; i < 8; i++) begin
      op_q[i] = primes[i % 5];
      op_a[i] = $urandom % {1'b0, op_q[i]};
      op_b[i] = $urandom % {1'b0, op_q[i]};
      op_gap[i] = 0;
    end
    n_ops = 8;
    base = n_out;
    run_batch("R5");
    for (int i = 1; i < 8; i++)
      chk(mon_cyc[base+i] - mon_cyc[base+i-1] == 4, "R5", "result spacing",
          mon_cyc[base+i] - mon_cyc[base+i-1], 4);
  endtask

  task automatic t_gaps();
    int gaps[6] = '{1, 3, 7, 0, 11, 2};
    for (int i = 0; i < 6; i++) begin
      op_q[i] = primes[(i + 2) % 5];
      op_a[i] = (i == 3) ? {1'b0, op_q[i]} - 1 : $urandom % {1'b0, op_q[i]};
      op_b[i] = $urandom % {1'b0, op_q[i]};
      op_gap[i] = gaps[i];
    end
    n_ops = 6;
    run_batch("R10");
  endtask

  task automatic t_stall();
    int base, c;
    logic [31:0] a, b;
    base = n_out;
    a = 32'd1999999999; b = 32'd2000000001;
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = 1'b1; a_i = a; b_i = b; q_i = primes[1]; mu_i = calc_mu(primes[1]);
    c = cyc;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk(in_ready_o == 1'b0, "R4", "ready low after accept", in_ready_o, 0);
      a_i = 32'd7 + k; b_i = 32'd11; q_i = primes[4]; mu_i = calc_mu(primes[4]);
    end
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R4", "ready back in 4th cycle", in_ready_o, 1);
    in_valid_i = 1'b0; a_i = '0; b_i = '0; q_i = '0; mu_i = '0;
    repeat (25) @(negedge clk_i);
    chk(n_out - base == 1, "R6", "results while stalled", n_out - base, 1);
    if (n_out > base) begin
      chk(mon_val[base] == ref_mod(a, b, primes[1]), "R6", "in-flight value",
          mon_val[base], ref_mod(a, b, primes[1]));
      chk(mon_cyc[base] == c + 19, "R3", "stall result cycle", mon_cyc[base], c + 19);
    end
  endtask

  task automatic t_idle();
    int base;
    base = n_out;
    in_valid_i = 1'b0;
    a_i = 32'd5; b_i = 32'd6; q_i = primes[0]; mu_i = calc_mu(primes[0]);
    repeat (40) @(negedge clk_i);
    chk(n_out == base, "R8", "outputs while idle", n_out - base, 0);
    a_i = '0; b_i = '0; q_i = '0; mu_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_corners();
    t_stream();
    t_gaps();
    t_stall();
    t_idle();
    summary();
  end
endmodule